// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives one conversion of a successive-approximation analog-to-digital converter. Software writes a control word with a go bit and a 3-bit clock select. From then on the block runs alone. It opens the sample/hold switch, lets one conversion-clock period pass for the hold node to settle, and resolves the result one bit at a time, most significant bit first. For each bit it puts a trial code on the DAC output and reads the comparator. After the last trial it loads the result register, drops the go bit and raises a sticky done flag, all on the same clock edge.

The conversion clock is derived from the system clock. Select codes 0 to 5 divide the system clock by 2, 4, 8, 16, 32 or 64. Codes 6 and 7 select an internal RC-mode clock with a period of `RC_PERIOD` system clocks. In RC mode the block first waits one instruction cycle of `CYC_CLKS` system clocks before the conversion clock starts. The comparator, the DAC and the holding capacitor lie outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, go_o, flag_o, result_o and dac_code_o are all zero and sample_o is 1.
- R2: ctl_sel_i codes 0 to 5 give a conversion-clock period of 2^(code+1) system clocks. Codes 6 and 7 give RC mode, with a period of RC_PERIOD system clocks.
- R3: In divider mode the conversion frame is RES_W+3 conversion-clock periods: one track-stop period, one settle period, RES_W trial periods and one load period. The result and flag appear on the clock edge (RES_W+3) x period system clocks after the edge that accepts the start write.
- R4: In RC mode, CYC_CLKS system clocks are added in front of the frame before the conversion clock runs.
- R5: sample_o is 1 while idle. It goes to 0 in the cycle after a start is accepted, stays 0 for the whole conversion, and is 1 again in the cycle the done flag appears.
- R6: Bits are resolved MSB first. During a trial, dac_code_o holds the bits already kept plus the current trial bit. cmp_i=1 means the input is at or above that level, and the trial bit is then kept. For an ideal comparator the result equals the input code.
- R7: On completion, go_o clears, flag_o sets and result_o loads, all on the same edge. result_o changes at no other time.
- R8: A control write while a conversion runs with the go bit at 1 is ignored. The conversion is neither restarted nor re-timed, and its select value is not taken. The select field is sampled only while idle.
- R9: A control write with the go bit at 0 during a conversion aborts it. On the next cycle go_o is 0 and sample_o is 1. result_o and flag_o stay unchanged.
- R10: flag_o stays set until a flag write with data 0 clears it. A flag write with data 1 has no effect. Hardware only ever sets the flag, and a set wins over a clear on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_go_i | input | 1 | Go bit of the control write (1 starts, 0 aborts) |
| ctl_sel_i | input | 3 | Conversion clock select of the control write |
| flag_we_i | input | 1 | Done-flag write strobe |
| flag_wd_i | input | 1 | Done-flag write data (0 clears) |
| cmp_i | input | 1 | Comparator: 1 when input is at or above dac_code_o |
| go_o | output | 1 | Go bit readback, 1 while a conversion runs |
| flag_o | output | 1 | Sticky done flag |
| result_o | output | RES_W | Result register |
| dac_code_o | output | RES_W | Trial code to the DAC |
| sample_o | output | 1 | Sample/hold switch, 1 = tracking |

## Verification
The bench builds the block with RES_W=6, CYC_CLKS=4 and RC_PERIOD=3. At that size it can convert every one of the 64 input codes under all eight select codes. Each run checks both the result and the exact edge on which it arrives, against a frame length computed from the select code. The small RC period and instruction-cycle length keep the RC-mode delay a distinct, countable number of cycles. The bench also runs mid-frame restart and abort writes, and every flag write pattern.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SEL_W     = 3;
    localparam int DIV_CODES = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RUN
    } seq_state_e;

    function automatic logic sel_is_rc(input logic [SEL_W-1:0] sel);
        return int'(sel) >= DIV_CODES;
    endfunction

    function automatic int unsigned div_ratio(input logic [SEL_W-1:0] sel);
        return 32'd1 << (int'(sel) + 1);
    endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen
    import sar_pkg::*;
#(
    parameter int RC_PERIOD = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int MAX_DIV = 1 << DIV_CODES;
    localparam int MAX_LIM = (RC_PERIOD > MAX_DIV) ? RC_PERIOD : MAX_DIV;
    localparam int CNT_W   = $clog2(MAX_LIM);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_reg_t;

    tick_reg_t   r_d, r_q;
    int unsigned lim;
    logic [CNT_W-1:0] last;

    always_comb begin
        lim    = sel_is_rc(sel_i) ? RC_PERIOD : div_ratio(sel_i);
        last   = CNT_W'(lim - 1);
        tick_o = en_i && (r_q.cnt == last);
        r_d    = r_q;
        if (!en_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == last) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int RES_W = 10
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     clr_i,
    input  logic                     trial_en_i,
    input  logic                     tick_i,
    input  logic [$clog2(RES_W)-1:0] bit_idx_i,
    input  logic                     cmp_i,
    output logic [RES_W-1:0]         acc_o,
    output logic [RES_W-1:0]         dac_o
);

    typedef struct packed {
        logic [RES_W-1:0] acc;
    } trial_reg_t;

    trial_reg_t       r_d, r_q;
    logic [RES_W-1:0] trial_bit;

    always_comb begin
        trial_bit = trial_en_i ? (RES_W'(1) << bit_idx_i) : '0;
        dac_o     = r_q.acc | trial_bit;
        acc_o     = r_q.acc;
        r_d       = r_q;
        if (clr_i) begin
            r_d.acc = '0;
        end else if (trial_en_i && tick_i && cmp_i) begin
            r_d.acc = r_q.acc | trial_bit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int CYC_CLKS  = 4,
    parameter int RC_PERIOD = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_we_i,
    input  logic             ctl_go_i,
    input  logic [2:0]       ctl_sel_i,
    input  logic             flag_we_i,
    input  logic             flag_wd_i,
    input  logic             cmp_i,
    output logic             go_o,
    output logic             flag_o,
    output logic [RES_W-1:0] result_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic             sample_o
);

    localparam int FRAME     = RES_W + 3;
    localparam int STEP_W    = $clog2(FRAME);
    localparam int IDX_W     = $clog2(RES_W);
    localparam int WAIT_W    = $clog2(CYC_CLKS + 1);
    localparam int LAST_STEP = FRAME - 1;
    localparam int FIRST_TRY = 2;
    localparam int LAST_TRY  = RES_W + 1;

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [WAIT_W-1:0] wait_cnt;
        logic [SEL_W-1:0]  sel;
        logic              flag;
        logic [RES_W-1:0]  result;
    } ctrl_reg_t;

    ctrl_reg_t         r_d, r_q;
    logic              tick;
    logic              start_ok;
    logic              done;
    logic              in_trial;
    logic [STEP_W-1:0] idx_wide;
    logic [IDX_W-1:0]  bit_idx;
    logic [RES_W-1:0]  acc;

    sar_tick_gen #(
        .RC_PERIOD (RC_PERIOD)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (r_q.state == ST_RUN),
        .sel_i  (r_q.sel),
        .tick_o (tick)
    );

    sar_trial_reg #(
        .RES_W (RES_W)
    ) u_trial (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (start_ok),
        .trial_en_i (in_trial),
        .tick_i     (tick),
        .bit_idx_i  (bit_idx),
        .cmp_i      (cmp_i),
        .acc_o      (acc),
        .dac_o      (dac_code_o)
    );

    always_comb begin
        in_trial = (r_q.state == ST_RUN)
                && (int'(r_q.step) >= FIRST_TRY)
                && (int'(r_q.step) <= LAST_TRY);
        idx_wide = STEP_W'(LAST_TRY) - r_q.step;
        bit_idx  = idx_wide[IDX_W-1:0];
    end

    always_comb begin
        r_d      = r_q;
        start_ok = 1'b0;
        done     = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (ctl_we_i) begin
                    r_d.sel = ctl_sel_i;
                    if (ctl_go_i) begin
                        start_ok     = 1'b1;
                        r_d.step     = '0;
                        r_d.wait_cnt = '0;
                        r_d.state    = sel_is_rc(ctl_sel_i) ? ST_HOLD : ST_RUN;
                    end
                end
            end
            ST_HOLD: begin
                if (ctl_we_i && !ctl_go_i) begin
                    r_d.state = ST_IDLE;
                end else if (int'(r_q.wait_cnt) == CYC_CLKS - 1) begin
                    r_d.state = ST_RUN;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (ctl_we_i && !ctl_go_i) begin
                    r_d.state = ST_IDLE;
                end else if (tick) begin
                    if (int'(r_q.step) == LAST_STEP) begin
                        done       = 1'b1;
                        r_d.state  = ST_IDLE;
                        r_d.result = acc;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (flag_we_i && !flag_wd_i) begin
            r_d.flag = 1'b0;
        end
        if (done) begin
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign go_o     = (r_q.state != ST_IDLE);
    assign sample_o = (r_q.state == ST_IDLE);
    assign flag_o   = r_q.flag;
    assign result_o = r_q.result;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int RES_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ctl_we_i,
    input logic             ctl_go_i,
    input logic             flag_we_i,
    input logic             flag_wd_i,
    input logic             go_o,
    input logic             flag_o,
    input logic [RES_W-1:0] result_o,
    input logic             sample_o
);

    AST_START_OPENS_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(go_o) |-> !sample_o); // R5

    AST_FLAG_WITH_GO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> $fell(go_o)); // R7

    AST_RESULT_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> ($fell(go_o) && flag_o)); // R7

    AST_ABORT_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_o && ctl_we_i && !ctl_go_i) |=> (!go_o && sample_o)); // R9

    AST_ABORT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_o && ctl_we_i && !ctl_go_i && !flag_o) |=> !flag_o); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !(flag_we_i && !flag_wd_i)) |=> flag_o); // R10

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .RES_W (RES_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_we_i  (ctl_we_i),
    .ctl_go_i  (ctl_go_i),
    .flag_we_i (flag_we_i),
    .flag_wd_i (flag_wd_i),
    .go_o      (go_o),
    .flag_o    (flag_o),
    .result_o  (result_o),
    .sample_o  (sample_o)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 6;
    localparam int CYC_CLKS   = 4;
    localparam int RC_PERIOD  = 3;
    localparam int FRAME      = RES_W + 3;
    localparam int WAIT_LIM   = 5000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0;
    logic             ctl_go = 1'b0;
    logic [2:0]       ctl_sel = '0;
    logic             flag_we = 1'b0;
    logic             flag_wd = 1'b0;
    logic             cmp;
    logic             go;
    logic             flag;
    logic [RES_W-1:0] result;
    logic [RES_W-1:0] dac;
    logic             sample;
    logic [RES_W-1:0] vin = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign cmp = (vin >= dac);

    sar_conv_ctrl #(
        .RES_W     (RES_W),
        .CYC_CLKS  (CYC_CLKS),
        .RC_PERIOD (RC_PERIOD)
    ) u_sar_conv_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ctl_we_i   (ctl_we),
        .ctl_go_i   (ctl_go),
        .ctl_sel_i  (ctl_sel),
        .flag_we_i  (flag_we),
        .flag_wd_i  (flag_wd),
        .cmp_i      (cmp),
        .go_o       (go),
        .flag_o     (flag),
        .result_o   (result),
        .dac_code_o (dac),
        .sample_o   (sample)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, cycles %0d expected below 190000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int frame_edges(input int sel);
        if (sel >= 6) return CYC_CLKS + FRAME * RC_PERIOD;
        return FRAME * (1 << (sel + 1));
    endfunction

    // drive a control write for one cycle; returns at the negedge after the accepting edge
    task automatic ctl_write(input bit g, input int sel);
        ctl_we  = 1'b1;
        ctl_go  = g;
        ctl_sel = 3'(sel);
        @(negedge clk);
        ctl_we  = 1'b0;
    endtask

    task automatic flag_write(input bit d);
        flag_we = 1'b1;
        flag_wd = d;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    // count negedges until flag is seen, starting from an already counted value
    task automatic wait_flag(inout int n);
        while (!flag && n < WAIT_LIM) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int hold_res;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(go == 1'b0, "R1 go", go, 0);
        chk(flag == 1'b0, "R1 flag", flag, 0);
        chk(result == '0, "R1 result", result, 0);
        chk(dac == '0, "R1 dac", dac, 0);
        chk(sample == 1'b1, "R1 sample", sample, 1);

        // R2 R3 R4 R5 R6 R7 sweep of every select code and every input code
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < (1 << RES_W); v++) begin
                vin = RES_W'(v);
                ctl_write(1'b1, s);
                n = 1;
                chk(sample == 1'b0, "R5 tracking stops", sample, 0);
                chk(go == 1'b1, "R7 go set while busy", go, 1);
                wait_flag(n);
                chk(n == frame_edges(s) + 1, (s >= 6) ? "R4 RC frame time" : "R3 R2 frame time",
                    n, frame_edges(s) + 1);
                chk(result == RES_W'(v), "R6 result", result, v);
                chk(go == 1'b0, "R7 go cleared", go, 0);
                chk(sample == 1'b1, "R5 tracking resumes", sample, 1);
                flag_write(1'b0);
                chk(flag == 1'b0, "R10 flag cleared", flag, 0);
            end
        end

        // R10 write of one has no effect, flag holds while idle
        flag_write(1'b1);
        chk(flag == 1'b0, "R10 write one on clear flag", flag, 0);
        vin = RES_W'(37);
        ctl_write(1'b1, 0);
        n = 1;
        wait_flag(n);
        repeat (40) @(negedge clk);
        chk(flag == 1'b1, "R10 flag holds", flag, 1);
        flag_write(1'b1);
        chk(flag == 1'b1, "R10 write one keeps flag", flag, 1);
        flag_write(1'b0);
        chk(flag == 1'b0, "R10 write zero clears", flag, 0);

        // R8 start write during a conversion with another select is ignored
        vin = RES_W'(21);
        ctl_write(1'b1, 0);
        n = 1;
        repeat (3) begin
            @(negedge clk);
            n++;
        end
        ctl_write(1'b1, 5);
        n++;
        chk(go == 1'b1, "R8 still busy", go, 1);
        wait_flag(n);
        chk(n == frame_edges(0) + 1, "R8 timing kept", n, frame_edges(0) + 1);
        chk(result == RES_W'(21), "R8 result", result, 21);
        flag_write(1'b0);
        // select kept from the original start: next start with code 1
        ctl_write(1'b1, 1);
        n = 1;
        wait_flag(n);
        chk(n == frame_edges(1) + 1, "R8 idle select taken", n, frame_edges(1) + 1);
        flag_write(1'b0);

        // R9 abort in divider mode
        hold_res = int'(result);
        vin = RES_W'(50);
        ctl_write(1'b1, 0);
        repeat (6) @(negedge clk);
        ctl_write(1'b0, 0);
        chk(go == 1'b0, "R9 abort go", go, 0);
        chk(sample == 1'b1, "R9 abort sample", sample, 1);
        repeat (60) @(negedge clk);
        chk(flag == 1'b0, "R9 abort no flag", flag, 0);
        chk(int'(result) == hold_res, "R9 abort result kept", result, hold_res);

        // R9 abort during the RC-mode delay
        ctl_write(1'b1, 7);
        @(negedge clk);
        ctl_write(1'b0, 7);
        chk(go == 1'b0, "R9 RC abort go", go, 0);
        repeat (60) @(negedge clk);
        chk(flag == 1'b0, "R9 RC abort no flag", flag, 0);
        chk(int'(result) == hold_res, "R9 RC abort result kept", result, hold_res);

        summary();
        $finish;
    end

endmodule